// File: doc/BRIEF.md
# Serial Audio Link Output Frame Builder

This block is the controller-side transmitter of a twelve-slot serial audio link. It runs on the bit clock that the codec supplies. It marks the start of each frame with a SYNC pulse and shifts one frame out on a single serial data line. Each frame is a 16-bit tag slot followed by twelve 20-bit slots, and every slot is sent most significant bit first.

Two valid/ready ports feed the frame. The first takes a register access: a read flag, a 7-bit register address and 16 bits of write data. The second takes a left/right PCM sample pair. Both ports accept only at a frame boundary. Whatever they accept is packed into the frame that starts on that same clock edge. The block sets a tag valid bit only for a slot that carries content. Every empty, unused or reserved bit position is sent as zero.

Top module: `aclink_tx_framer`

## Requirements
- R1: A frame lasts 256 bit clocks (16 + 12 x 20). `sync` changes on the rising clock edge. It goes high on the first edge of each frame, stays high for exactly 16 bit clocks, and is low for the rest of the frame.
- R2: The first tag bit (bit 15) appears on `sdata_out` one rising edge after `sync` rises. Tag, slot 1, slot 2 and so on up to slot 12 then follow, one bit per clock, each slot MSB first.
- R3: Tag bit 15 is 1 when any slot carries content. Bit 14 is 1 when slot 1 holds a request. Bit 13 is 1 when slot 2 holds write data. Bits 12 and 11 are 1 when slots 3 and 4 hold PCM.
- R4: Slot 1 carries the read flag in bit 19 (1 = read, 0 = write) and the register address in bits 18:12. Bits 11:0 are zero.
- R5: On a write, slot 2 carries the 16 data bits in bits 19:4, with bits 3:0 zero. On a read, all of slot 2 is zero and tag bit 13 is clear.
- R6: Slot 3 carries the left sample and slot 4 the right sample. Only the top 18 bits of each 20-bit sample are sent. Bits 1:0 of each slot are zero.
- R7: Tag bits 10:0 are zero, and slots 5 through 12 are sent as all zeros.
- R8: `reg_ready` and `pcm_ready` are high only during the last bit clock of a frame. A handshake completed on the following edge places its content in the frame that starts on that edge.
- R9: An accepted request occupies exactly one frame. In a frame with no accepted request, tag bits 14 and 13 are clear and slots 1 and 2 are zero. In a frame with no accepted sample pair, tag bits 12 and 11 are clear and slots 3 and 4 are zero.
- R10: During reset, `sync` and `sdata_out` are low. The first frame starts on the first rising edge after reset is released, and both ports are ready in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| reg_valid | input | 1 | A register access is offered |
| reg_ready | output | 1 | The register access is accepted on this edge |
| reg_rd | input | 1 | 1 = read, 0 = write |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Write data |
| pcm_valid | input | 1 | A sample pair is offered |
| pcm_ready | output | 1 | The sample pair is accepted on this edge |
| pcm_left | input | 20 | Left PCM sample |
| pcm_right | input | 20 | Right PCM sample |
| sync | output | 1 | Frame-start marker |
| sdata_out | output | 1 | Serial frame data |

## Verification
The bench builds the block with its default parameters: a 16-bit tag, twelve 20-bit slots, a 7-bit address, 16-bit data, and 20-bit samples of which 18 bits are kept. With these values the whole 256-bit frame is captured and compared field by field with a frame the bench rebuilds itself. The same capture checks the 16-clock SYNC window and the one-cycle ready window against exact bit positions. The PCM test samples have their low two bits set, so a missing truncation shows up in slots 3 and 4. Consecutive frames show that a request is sent exactly once, and that a read and a write sent back to back keep their slot 2 contents apart.

// File: rtl/aclink_tx_pkg.sv
`timescale 1ns/1ps
package aclink_tx_pkg;
  // Number of slots after the tag that may carry content (1..4)
  localparam int PAYLOAD_SLOTS = 4;
  // Tag bit offsets, counted down from the tag MSB
  localparam int TAG_OFS_FRAME = 0;
  localparam int TAG_OFS_CMD   = 1;
  localparam int TAG_OFS_DATA  = 2;
  localparam int TAG_OFS_LEFT  = 3;
  localparam int TAG_OFS_RIGHT = 4;
  localparam int TAG_USED_BITS = 5;
endpackage

// File: rtl/aclink_tx_timer.sv
`timescale 1ns/1ps
module aclink_tx_timer #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int SIW = $clog2(NUM_SLOTS + 1),
  localparam int BIW = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [SIW-1:0] slot_idx,
  output logic [BIW-1:0] bit_idx,
  output logic           frame_last,
  output logic           sync
);
  localparam logic [SIW-1:0] LAST_SLOT = SIW'(NUM_SLOTS);
  localparam logic [BIW-1:0] TAG_TOP   = BIW'(TAG_W - 1);
  localparam logic [BIW-1:0] SLOT_TOP  = BIW'(SLOT_W - 1);

  logic           slot_end;
  logic [SIW-1:0] slot_nxt;
  logic [BIW-1:0] bit_nxt;
  logic           sync_nxt;

  always_comb begin
    slot_end   = (bit_idx == '0);
    frame_last = slot_end && (slot_idx == LAST_SLOT);
    if (frame_last) begin
      slot_nxt = '0;
      bit_nxt  = TAG_TOP;
    end else if (slot_end) begin
      slot_nxt = slot_idx + 1'b1;
      bit_nxt  = SLOT_TOP;
    end else begin
      slot_nxt = slot_idx;
      bit_nxt  = bit_idx - 1'b1;
    end
    // high while the next position lies inside the tag slot
    sync_nxt = (slot_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_idx <= LAST_SLOT;
      bit_idx  <= '0;
      sync     <= 1'b0;
    end else begin
      slot_idx <= slot_nxt;
      bit_idx  <= bit_nxt;
      sync     <= sync_nxt;
    end
  end

  // R1
  sync_rise_at_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> (slot_idx == '0) && (bit_idx == TAG_TOP));
  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> sync && (slot_idx == '0));
  // R1
  sync_only_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (slot_idx == '0));
endmodule

// File: rtl/aclink_tx_slot_packer.sv
`timescale 1ns/1ps
module aclink_tx_slot_packer
  import aclink_tx_pkg::*;
#(
  parameter int TAG_W    = 16,
  parameter int SLOT_W   = 20,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int PCM_W    = 20,
  parameter int PCM_KEEP = 18
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  load,
  input  logic                                  reg_valid,
  output logic                                  reg_ready,
  input  logic                                  reg_rd,
  input  logic [ADDR_W-1:0]                     reg_addr,
  input  logic [DATA_W-1:0]                     reg_wdata,
  input  logic                                  pcm_valid,
  output logic                                  pcm_ready,
  input  logic [PCM_W-1:0]                      pcm_left,
  input  logic [PCM_W-1:0]                      pcm_right,
  output logic [TAG_W-1:0]                      tag,
  output logic [PAYLOAD_SLOTS-1:0][SLOT_W-1:0]  payload
);
  logic              cmd_v_q, cmd_rd_q, pcm_v_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [DATA_W-1:0] cmd_data_q;
  logic [PCM_W-1:0]  left_q, right_q;

  function automatic logic [TAG_W-1:0] pack_tag(input logic cv, input logic rd, input logic pv);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1-TAG_OFS_FRAME] = cv | pv;
    t[TAG_W-1-TAG_OFS_CMD]   = cv;
    t[TAG_W-1-TAG_OFS_DATA]  = cv & ~rd;
    t[TAG_W-1-TAG_OFS_LEFT]  = pv;
    t[TAG_W-1-TAG_OFS_RIGHT] = pv;
    return t;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_addr(input logic cv, input logic rd, input logic [ADDR_W-1:0] a);
    logic [SLOT_W-1:0] s;
    s = '0;
    if (cv) begin
      s[SLOT_W-1]           = rd;
      s[SLOT_W-2 -: ADDR_W] = a;
    end
    return s;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_data(input logic cv, input logic rd, input logic [DATA_W-1:0] d);
    logic [SLOT_W-1:0] s;
    s = '0;
    if (cv && !rd) s[SLOT_W-1 -: DATA_W] = d;
    return s;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_pcm(input logic pv, input logic [PCM_W-1:0] smp);
    logic [SLOT_W-1:0] s;
    s = '0;
    if (pv) s[SLOT_W-1 -: PCM_KEEP] = smp[PCM_W-1 -: PCM_KEEP];
    return s;
  endfunction

  assign reg_ready = load;
  assign pcm_ready = load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_v_q    <= 1'b0;
      cmd_rd_q   <= 1'b0;
      cmd_addr_q <= '0;
      cmd_data_q <= '0;
      pcm_v_q    <= 1'b0;
      left_q     <= '0;
      right_q    <= '0;
    end else if (load) begin
      cmd_v_q    <= reg_valid;
      cmd_rd_q   <= reg_rd;
      cmd_addr_q <= reg_addr;
      cmd_data_q <= reg_wdata;
      pcm_v_q    <= pcm_valid;
      left_q     <= pcm_left;
      right_q    <= pcm_right;
    end
  end

  always_comb begin
    tag        = pack_tag(cmd_v_q, cmd_rd_q, pcm_v_q);
    payload[0] = pack_addr(cmd_v_q, cmd_rd_q, cmd_addr_q);
    payload[1] = pack_data(cmd_v_q, cmd_rd_q, cmd_data_q);
    payload[2] = pack_pcm(pcm_v_q, left_q);
    payload[3] = pack_pcm(pcm_v_q, right_q);
  end

  // R9
  cmd_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && reg_valid) |=> tag[TAG_W-1-TAG_OFS_CMD] && tag[TAG_W-1-TAG_OFS_FRAME]);
  // R9
  cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !reg_valid) |=> !tag[TAG_W-1-TAG_OFS_CMD] && (payload[0] == '0) && (payload[1] == '0));
  // R5
  read_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && reg_valid && reg_rd) |=> (payload[1] == '0) && !tag[TAG_W-1-TAG_OFS_DATA]);
  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(tag) && $stable(payload));
endmodule

// File: rtl/aclink_tx_serializer.sv
`timescale 1ns/1ps
module aclink_tx_serializer
  import aclink_tx_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int SIW = $clog2(NUM_SLOTS + 1),
  localparam int BIW = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [SIW-1:0]                        slot_idx,
  input  logic [BIW-1:0]                        bit_idx,
  input  logic [TAG_W-1:0]                      tag,
  input  logic [PAYLOAD_SLOTS-1:0][SLOT_W-1:0]  payload,
  output logic                                  sdata_out
);
  localparam logic [BIW-1:0] TAG_TOP = BIW'(TAG_W - 1);

  logic [SLOT_W-1:0] lane [NUM_SLOTS+1];
  logic              cur_bit;

  for (genvar s = 0; s <= NUM_SLOTS; s++) begin : g_lane
    if (s == 0) begin : g_tag
      assign lane[s] = SLOT_W'(tag);
    end else if (s <= PAYLOAD_SLOTS) begin : g_data
      assign lane[s] = payload[s-1];
    end else begin : g_rsvd
      assign lane[s] = '0;
    end
  end

  always_comb begin
    cur_bit = lane[slot_idx][bit_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sdata_out <= 1'b0;
    else        sdata_out <= cur_bit;
  end

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx > SIW'(PAYLOAD_SLOTS)) |=> !sdata_out);
  // R7
  tag_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_idx == '0) && (bit_idx < BIW'(TAG_W - TAG_USED_BITS))) |=> !sdata_out);
  // R2
  tag_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_idx == '0) && (bit_idx == TAG_TOP)) |=> (sdata_out == $past(tag[TAG_W-1])));
endmodule

// File: rtl/aclink_tx_framer.sv
`timescale 1ns/1ps
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 20,
  parameter int PCM_KEEP  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              pcm_valid,
  output logic              pcm_ready,
  input  logic [PCM_W-1:0]  pcm_left,
  input  logic [PCM_W-1:0]  pcm_right,
  output logic              sync,
  output logic              sdata_out
);
  localparam int SIW = $clog2(NUM_SLOTS + 1);
  localparam int BIW = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W);

  logic [SIW-1:0]                       slot_idx;
  logic [BIW-1:0]                       bit_idx;
  logic                                 frame_last;
  logic [TAG_W-1:0]                     tag;
  logic [PAYLOAD_SLOTS-1:0][SLOT_W-1:0] payload;

  aclink_tx_timer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .frame_last(frame_last), .sync(sync)
  );

  aclink_tx_slot_packer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PCM_W(PCM_W), .PCM_KEEP(PCM_KEEP)
  ) u_packer (
    .clk(clk), .rst_n(rst_n), .load(frame_last),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
    .pcm_left(pcm_left), .pcm_right(pcm_right),
    .tag(tag), .payload(payload)
  );

  aclink_tx_serializer #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .bit_idx(bit_idx),
    .tag(tag), .payload(payload), .sdata_out(sdata_out)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !sync && !sdata_out);
endmodule

// File: tb/aclink_tx_framer_test.sv
`timescale 1ns/1ps
module aclink_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        pcm_valid = 1'b0;
  logic [19:0] pcm_left = '0, pcm_right = '0;
  logic        reg_ready, pcm_ready, sync, sdata_out;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aclink_tx_framer uut (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
    .pcm_left(pcm_left), .pcm_right(pcm_right),
    .sync(sync), .sdata_out(sdata_out)
  );

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Frame as the requirements lay it out, first serial bit at index 255
  function automatic logic [255:0] build_frame(input bit cv, input bit rd, input logic [6:0] a,
      input logic [15:0] d, input bit pv, input logic [19:0] l, input logic [19:0] r);
    logic [15:0] t;
    logic [19:0] s_addr, s_data, s_left, s_right;
    t       = {cv | pv, cv, cv & ~rd, pv, pv, 11'd0};
    s_addr  = cv ? {rd, a, 12'd0} : 20'd0;
    s_data  = (cv && !rd) ? {d, 4'd0} : 20'd0;
    s_left  = pv ? {l[19:2], 2'b00} : 20'd0;
    s_right = pv ? {r[19:2], 2'b00} : 20'd0;
    return {t, s_addr, s_data, s_left, s_right, 160'd0};
  endfunction

  // Offers the inputs, waits for the boundary handshake, captures the frame
  task automatic run_frame(input string name, input bit cv, input bit rd, input logic [6:0] a,
      input logic [15:0] d, input bit pv, input logic [19:0] l, input logic [19:0] r);
    logic [255:0] cap, exp;
    int sync_bad, rdy_bad;
    sync_bad = 0;
    rdy_bad  = 0;
    cap      = '0;
    reg_valid = cv; reg_rd = rd; reg_addr = a; reg_wdata = d;
    pcm_valid = pv; pcm_left = l; pcm_right = r;
    while (!(reg_ready && pcm_ready)) @(negedge clk);
    @(negedge clk);
    // R7: final bit of the previous frame (slot 12) is zero
    check("R7", {name, " previous slot 12 last bit"}, 256'(sdata_out), 256'd0);
    // R1: sync has just risen
    check("R1", {name, " sync at frame start"}, 256'(sync), 256'd1);
    // change the port values after acceptance: the frame must not follow them
    reg_valid = 1'b0; pcm_valid = 1'b0;
    reg_addr = ~a; reg_wdata = ~d; pcm_left = ~l; pcm_right = ~r; reg_rd = ~rd;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk);
      cap[255-i] = sdata_out;
      if (sync !== (i < 15)) sync_bad++;
      if ((reg_ready !== (i == 254)) || (pcm_ready !== (i == 254))) rdy_bad++;
    end
    exp = build_frame(cv, rd, a, d, pv, l, r);
    // R2: whole frame in MSB-first order
    check("R2", {name, " full frame"}, cap, exp);
    check("R3", {name, " tag slot"}, 256'(cap[255:240]), 256'(exp[255:240]));
    check("R4", {name, " slot 1"}, 256'(cap[239:220]), 256'(exp[239:220]));
    check("R5", {name, " slot 2"}, 256'(cap[219:200]), 256'(exp[219:200]));
    check("R6", {name, " slots 3-4"}, 256'(cap[199:160]), 256'(exp[199:160]));
    check("R7", {name, " reserved slots"}, 256'(cap[159:0]), 256'd0);
    check("R1", {name, " sync window mismatches"}, 256'(sync_bad), 256'd0);
    check("R8", {name, " ready window mismatches"}, 256'(rdy_bad), 256'd0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    // R10: quiet during reset
    check("R10", "sync in reset", 256'(sync), 256'd0);
    check("R10", "sdata in reset", 256'(sdata_out), 256'd0);
    rst_n = 1'b1;
    // R10: ready in the cycle before the first frame edge
    check("R10", "ready after reset release", 256'({reg_ready, pcm_ready}), 256'd3);
  endtask

  task automatic test_first_frame_idle();
    // R10, R9: first frame carries nothing
    run_frame("R10 first idle frame", 1'b0, 1'b0, 7'h00, 16'h0000, 1'b0, 20'h0, 20'h0);
  endtask

  task automatic test_write_with_pcm();
    run_frame("R5 write+pcm", 1'b0 | 1'b1, 1'b0, 7'h2A, 16'hBEEF, 1'b1, 20'hABCDF, 20'h13577);
  endtask

  task automatic test_read_only();
    // R5: read blanks slot 2 even with nonzero data offered
    run_frame("R5 read", 1'b1, 1'b1, 7'h7F, 16'hFFFF, 1'b0, 20'hFFFFF, 20'hFFFFF);
  endtask

  task automatic test_request_once();
    // R9: request in one frame, next frame empty
    run_frame("R9 write once", 1'b1, 1'b0, 7'h01, 16'h8001, 1'b0, 20'h0, 20'h0);
    run_frame("R9 following frame", 1'b0, 1'b0, 7'h55, 16'h1234, 1'b0, 20'h0, 20'h0);
  endtask

  task automatic test_pcm_only();
    // R6: low two bits dropped
    run_frame("R6 pcm only", 1'b0, 1'b0, 7'h33, 16'hAAAA, 1'b1, 20'h80003, 20'h7FFFF);
  endtask

  task automatic test_back_to_back();
    // R8: consecutive boundaries accept consecutive requests
    run_frame("R8 read then", 1'b1, 1'b1, 7'h26, 16'h5A5A, 1'b1, 20'h00001, 20'hFFFFE);
    run_frame("R8 write next", 1'b1, 1'b0, 7'h26, 16'h5A5A, 1'b1, 20'h12345, 20'h6789A);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    test_reset();
    test_first_frame_idle();
    test_write_with_pcm();
    test_read_only();
    test_request_once();
    test_pcm_only();
    test_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule